// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked monostable. It watches three control inputs: a trigger that acts on its falling edge, a trigger that acts on its rising edge, and an active-low clear. It produces a pulse of programmable length on a true output and a complementary output. The pulse length is a tick count presented on a width input. That count replaces the resistor and capacitor network of a discrete one-shot. The block samples every input once per clock and finds edges by comparing each sample with the one taken a cycle earlier.

A qualifying edge starts a pulse. The same edge arriving while a pulse is running reloads the timer with the full width, so the pulse is stretched rather than left to expire. Clear overrides everything. A trigger that lands on the final tick of a pulse keeps the output high with no gap.

The controller has three states. `OS_IDLE` means no pulse. `OS_RUN` means a pulse with more than one tick still to go. `OS_LAST` is the final tick of a pulse. The transitions are:
- start: idle to run or last, on a trigger.
- reload: run or last back to run or last, on a trigger.
- count: run to run, decrementing the timer.
- final: run to last, when one tick remains.
- expire: last to idle, when no trigger arrives.
- abort: any state to idle, while clear is low.

Top module: `retrig_oneshot`

## Requirements
- R1: After reset the outputs are `pulse_o`=0 and `pulse_n_o`=1. The edge history resets so that inputs which are already steady when reset is released do not start a pulse.
- R2: While `clear_n_i` is 0, `pulse_o` is 0 and `pulse_n_o` is 1 in that same cycle. A running pulse is abandoned and does not resume when clear returns high without a trigger.
- R3: A 1-to-0 change of `fall_trig_i`, seen while `rise_trig_i` and `clear_n_i` are both 1, is a trigger.
- R4: A 0-to-1 change of `rise_trig_i`, seen while `fall_trig_i` is 0 and `clear_n_i` is 1, is a trigger.
- R5: A 0-to-1 change of `clear_n_i`, seen while `fall_trig_i` is 0 and `rise_trig_i` is 1, is a trigger.
- R6: Any other input change leaves the outputs unchanged. Examples are a falling trigger edge with the rising input low, a rising edge with the falling input high, a clear release with the falling input high, and any edge while clear is low.
- R7: A trigger sampled at clock edge k drives `pulse_o` high from edge k. The pulse stays high for exactly W cycles, where W is the value of `width_i` at that edge. Later changes to `width_i` do not alter a pulse already loaded.
- R8: A `width_i` of 0 gives a pulse of 1 cycle.
- R9: A trigger sampled j cycles after the start of a running pulse reloads the full width. The output stays high for j+W cycles in total.
- R10: A trigger sampled on the last high cycle of a pulse extends the pulse with no low cycle between the two intervals.
- R11: `pulse_n_o` is the complement of `pulse_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and state clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fall_trig_i | input | 1 | Trigger that acts on its falling edge |
| rise_trig_i | input | 1 | Trigger that acts on its rising edge |
| clear_n_i | input | 1 | Clear, active low. Its release can also trigger |
| width_i | input | WIDTH_W | Pulse length in clock ticks, with 0 read as 1 |
| pulse_o | output | 1 | Pulse output, high while timing |
| pulse_n_o | output | 1 | Complement of the pulse output |

## Verification
Each of the three trigger kinds is swept over widths 0 to 6 plus the largest width. The expected high span is computed from the width alone, which separates a correct load from an off-by-one count and confirms the zero-width rule. For the two edge triggers, retriggers are placed at every offset from the second cycle up to the expiry tick. The expected span of offset plus width separates a true reload from a trigger that is ignored or that extends the pulse only by what remained. The offset equal to the width exercises the expiry collision. Further cases cover:
- a width change in mid-pulse, which separates capture at the trigger from a live read;
- clear inside a pulse and edges with the wrong qualifier, which show that only the three qualified edges and nothing else move the output.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Controller states of the pulse generator
    typedef enum logic [1:0] {
        OS_IDLE = 2'd0,
        OS_RUN  = 2'd1,
        OS_LAST = 2'd2
    } os_state_e;

    // Bit positions inside the sampled input vector
    localparam int SMP_FALL  = 0;
    localparam int SMP_RISE  = 1;
    localparam int SMP_CLEAR = 2;
    localparam int SMP_BITS  = 3;

    // History reset: falling-trigger history low, rising-trigger history high,
    // clear history high, so no edge is seen on the first sample after reset
    localparam logic [SMP_BITS-1:0] SMP_RST_VAL = 3'b110;

endpackage

// File: rtl/oneshot_edge_sampler.sv
module oneshot_edge_sampler #(
    parameter int                 N_BITS  = 3,
    parameter logic [N_BITS-1:0]  RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] din_i,
    output logic [N_BITS-1:0] prev_o
);

    logic [N_BITS-1:0] prev_q;

    for (genvar gi = 0; gi < N_BITS; gi++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[gi] <= RST_VAL[gi];
            end else begin
                prev_q[gi] <= din_i[gi];
            end
        end
    end

    assign prev_o = prev_q;

endmodule

// File: rtl/oneshot_trig_qual.sv
module oneshot_trig_qual
    import oneshot_pkg::*;
(
    input  logic [SMP_BITS-1:0] cur_i,
    input  logic [SMP_BITS-1:0] prev_i,
    output logic                fire_o
);

    logic fall_now, rise_now, clr_now;
    logic fall_was, rise_was, clr_was;
    logic hit_fall, hit_rise, hit_clear;

    always_comb begin
        fall_now  = cur_i[SMP_FALL];
        rise_now  = cur_i[SMP_RISE];
        clr_now   = cur_i[SMP_CLEAR];
        fall_was  = prev_i[SMP_FALL];
        rise_was  = prev_i[SMP_RISE];
        clr_was   = prev_i[SMP_CLEAR];

        // falling edge on the falling trigger, rising input high
        hit_fall  = fall_was & ~fall_now & rise_now;
        // rising edge on the rising trigger, falling input low
        hit_rise  = ~rise_was & rise_now & ~fall_now;
        // release of clear, falling input low and rising input high
        hit_clear = ~clr_was & ~fall_now & rise_now;

        fire_o    = clr_now & (hit_fall | hit_rise | hit_clear);
    end

endmodule

// File: rtl/oneshot_interval.sv
module oneshot_interval #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               load_i,
    input  logic               dec_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               single_o,
    output logic               rem_one_o
);

    localparam logic [WIDTH_W-1:0] ONE = WIDTH_W'(1);

    logic [WIDTH_W-1:0] eff_w;
    logic [WIDTH_W-1:0] rem_q;

    always_comb begin
        eff_w    = (width_i == '0) ? ONE : width_i;
        single_o = (eff_w == ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (flush_i) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= eff_w - ONE;
        end else if (dec_i && rem_q != '0) begin
            rem_q <= rem_q - ONE;
        end
    end

    assign rem_one_o = (rem_q == ONE);

endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
    import oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_n_i,
    input  logic fire_i,
    input  logic single_i,
    input  logic rem_one_i,
    output logic load_o,
    output logic dec_o,
    output logic pulse_o,
    output logic pulse_n_o
);

    os_state_e state_q, state_d;

    // next-state and timer control
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        dec_o   = 1'b0;
        if (!clear_n_i) begin
            state_d = OS_IDLE;                          // abort
        end else if (fire_i) begin
            load_o  = 1'b1;                             // start / reload
            state_d = single_i ? OS_LAST : OS_RUN;
        end else begin
            unique case (state_q)
                OS_IDLE: state_d = OS_IDLE;
                OS_RUN: begin
                    dec_o   = 1'b1;                     // count
                    state_d = rem_one_i ? OS_LAST : OS_RUN; // final
                end
                OS_LAST: state_d = OS_IDLE;             // expire
                default: state_d = OS_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        pulse_o   = (state_q != OS_IDLE) && clear_n_i;
        pulse_n_o = ~pulse_o;
    end

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fall_trig_i,
    input  logic               rise_trig_i,
    input  logic               clear_n_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               pulse_o,
    output logic               pulse_n_o
);

    logic [SMP_BITS-1:0] smp_cur;
    logic [SMP_BITS-1:0] smp_prev;
    logic                fire;
    logic                load, dec, single, rem_one;

    always_comb begin
        smp_cur            = '0;
        smp_cur[SMP_FALL]  = fall_trig_i;
        smp_cur[SMP_RISE]  = rise_trig_i;
        smp_cur[SMP_CLEAR] = clear_n_i;
    end

    oneshot_edge_sampler #(
        .N_BITS  (SMP_BITS),
        .RST_VAL (SMP_RST_VAL)
    ) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (smp_cur),
        .prev_o (smp_prev)
    );

    oneshot_trig_qual u_qual (
        .cur_i  (smp_cur),
        .prev_i (smp_prev),
        .fire_o (fire)
    );

    oneshot_interval #(
        .WIDTH_W (WIDTH_W)
    ) u_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (~clear_n_i),
        .load_i    (load),
        .dec_i     (dec),
        .width_i   (width_i),
        .single_o  (single),
        .rem_one_o (rem_one)
    );

    oneshot_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_n_i (clear_n_i),
        .fire_i    (fire),
        .single_i  (single),
        .rem_one_i (rem_one),
        .load_o    (load),
        .dec_o     (dec),
        .pulse_o   (pulse_o),
        .pulse_n_o (pulse_n_o)
    );

endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
    parameter int WIDTH_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fall_trig_i,
    input logic               rise_trig_i,
    input logic               clear_n_i,
    input logic [WIDTH_W-1:0] width_i,
    input logic               pulse_o,
    input logic               pulse_n_o
);

    logic               a_h, b_h, c_h;
    logic               ev_a, ev_b, ev_c, ev_any;
    logic [WIDTH_W-1:0] cap_r;
    logic [WIDTH_W:0]   since;
    logic               alive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_h <= 1'b0;
            b_h <= 1'b1;
            c_h <= 1'b1;
        end else begin
            a_h <= fall_trig_i;
            b_h <= rise_trig_i;
            c_h <= clear_n_i;
        end
    end

    always_comb begin
        ev_a   = clear_n_i & a_h & ~fall_trig_i & rise_trig_i;
        ev_b   = clear_n_i & ~b_h & rise_trig_i & ~fall_trig_i;
        ev_c   = clear_n_i & ~c_h & ~fall_trig_i & rise_trig_i;
        ev_any = ev_a | ev_b | ev_c;
    end

    // window tracker: ticks since the last trigger, and width captured then
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_r <= '0;
            since <= '0;
            alive <= 1'b0;
        end else if (ev_any) begin
            cap_r <= (width_i == '0) ? WIDTH_W'(1) : width_i;   // R8 zero width
            since <= '0;
            alive <= 1'b1;
        end else begin
            if (!clear_n_i) alive <= 1'b0;
            if (since != {(WIDTH_W+1){1'b1}}) since <= since + 1'b1;
        end
    end

    AST_CLEAR_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n_i |-> (!pulse_o && pulse_n_o)); // R2
    AST_COMPLEMENT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_n_o == !pulse_o); // R11
    AST_FALL_EDGE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_a |=> (pulse_o || !clear_n_i)); // R3
    AST_RISE_EDGE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_b |=> (pulse_o || !clear_n_i)); // R4
    AST_CLEAR_RELEASE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_c |=> (pulse_o || !clear_n_i)); // R5
    AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_o && !ev_any) |=> !pulse_o); // R6
    AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (since < {1'b0, cap_r})); // R7
    AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (alive && clear_n_i && since < {1'b0, cap_r}) |-> pulse_o); // R9

endmodule

bind retrig_oneshot retrig_oneshot_chk #(.WIDTH_W(WIDTH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_trig_i (fall_trig_i),
    .rise_trig_i (rise_trig_i),
    .clear_n_i   (clear_n_i),
    .width_i     (width_i),
    .pulse_o     (pulse_o),
    .pulse_n_o   (pulse_n_o)
);

// File: tb/retrig_oneshot_bench.sv
module retrig_oneshot_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH_W    = 8;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               fa, rb, cn;
    logic [WIDTH_W-1:0] width;
    logic               q, qn;
    int                 checks   = 0;
    int                 failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    retrig_oneshot #(.WIDTH_W(WIDTH_W)) u_retrig_oneshot (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_trig_i (fa),
        .rise_trig_i (rb),
        .clear_n_i   (cn),
        .width_i     (width),
        .pulse_o     (q),
        .pulse_n_o   (qn)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic na, input logic nb, input logic nc);
        @(negedge clk);
        fa = na; rb = nb; cn = nc;
        @(posedge clk);
        #1;
    endtask

    // kind 0: falling trigger, 1: rising trigger, 2: clear release
    task automatic run_case(input int kind, input int w, input int k, input int w2,
                            input string req);
        int eff, eff2, stop, bad, got;
        logic exp;
        eff  = (w == 0) ? 1 : w;
        eff2 = (w2 == 0) ? 1 : w2;
        stop = (k == 0) ? eff : k + eff2;
        bad  = -1;
        got  = 0;
        width = w[WIDTH_W-1:0];
        step(1, 0, 0);
        step(1, 0, 0);
        if (kind == 0) begin step(1, 1, 1); step(1, 1, 1); end
        else if (kind == 1) begin step(0, 0, 1); step(0, 0, 1); end
        else begin step(0, 1, 0); step(0, 1, 0); end
        for (int cyc = 0; cyc < stop + 4; cyc++) begin
            bit act;
            act = (cyc == 0) || (k != 0 && cyc == k);
            if (kind == 0)      step(act ? 1'b0 : 1'b1, 1'b1, 1'b1);
            else if (kind == 1) step(1'b0, act ? 1'b1 : 1'b0, 1'b1);
            else                step(1'b0, 1'b1, 1'b1);
            if (cyc == 0) width = w2[WIDTH_W-1:0];
            exp = (cyc < stop);
            if (q) got++;
            if ((q !== exp || qn !== !exp) && bad < 0) bad = cyc;
        end
        check(bad < 0 && got == stop, req, got, stop);
    endtask

    task automatic quiet(input logic a0, input logic b0, input logic c0,
                         input logic a1, input logic b1, input logic c1, input string req);
        int seen;
        seen = 0;
        step(1, 0, 0);
        step(1, 0, 0);
        step(a0, b0, c0);
        step(a0, b0, c0);
        for (int i = 0; i < 4; i++) begin
            step(a1, b1, c1);
            if (q !== 1'b0 || qn !== 1'b1) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seen;
        rst_n = 1'b0;
        fa = 1'b0; rb = 1'b1; cn = 1'b1;
        width = 8'd3;
        repeat (3) @(posedge clk);
        #1;
        check(q === 1'b0 && qn === 1'b1, "R1 reset outputs", q, 0);
        @(negedge clk);
        rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            if (q !== 1'b0) seen++;
        end
        check(seen == 0, "R1 no pulse from steady inputs at release", seen, 0);

        // width sweep for each trigger kind (R3 R4 R5 R7 R8 R11)
        for (int w = 0; w <= 6; w++) begin
            run_case(0, w, 0, w, (w == 0) ? "R8 R3 falling trigger zero width" : "R3 R7 falling trigger width");
            run_case(1, w, 0, w, (w == 0) ? "R8 R4 rising trigger zero width" : "R4 R7 rising trigger width");
            run_case(2, w, 0, w, (w == 0) ? "R8 R5 clear release zero width" : "R5 R7 clear release width");
        end
        run_case(1, 255, 0, 255, "R7 largest width");

        // retrigger at every offset, offset == width is the expiry tick (R9 R10)
        for (int w = 2; w <= 6; w++) begin
            for (int k = 2; k <= w; k++) begin
                run_case(0, w, k, w, (k == w) ? "R10 falling retrigger on expiry" : "R9 falling retrigger reload");
                run_case(1, w, k, w, (k == w) ? "R10 rising retrigger on expiry" : "R9 rising retrigger reload");
            end
        end
        run_case(1, 4, 3, 6, "R9 retrigger loads current width");

        // width change mid-pulse has no effect (R7)
        run_case(1, 5, 0, 2, "R7 width captured at trigger shrink");
        run_case(0, 2, 0, 7, "R7 width captured at trigger grow");

        // qualifier violations (R6 R2)
        quiet(1, 0, 1, 0, 0, 1, "R6 falling edge with rising input low");
        quiet(1, 0, 1, 1, 1, 1, "R6 rising edge with falling input high");
        quiet(1, 1, 0, 1, 1, 1, "R6 clear release with falling input high");
        quiet(0, 0, 0, 0, 0, 1, "R6 clear release with rising input low");
        quiet(1, 1, 0, 0, 1, 0, "R2 falling edge while clear low");
        quiet(0, 0, 0, 0, 1, 0, "R2 rising edge while clear low");

        // clear inside a pulse (R2 R11)
        width = 8'd10;
        step(1, 0, 0);
        step(0, 0, 1);
        step(0, 1, 1);
        step(0, 0, 1);
        step(0, 0, 1);
        check(q === 1'b1 && qn === 1'b0, "R11 pulse running before clear", q, 1);
        @(negedge clk);
        cn = 1'b0; fa = 1'b1; rb = 1'b1;
        #1;
        check(q === 1'b0 && qn === 1'b1, "R2 clear forces outputs in same cycle", q, 0);
        @(posedge clk); #1;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            step(1, 1, 1);
            if (q !== 1'b0 || qn !== 1'b1) seen++;
        end
        check(seen == 0, "R2 aborted pulse does not resume", seen, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule